// File: doc/BRIEF.md
# Breakdown Voltage Bin Calibrator

This block calibrates an array of photon-detecting pixels against the spread of their avalanche breakdown voltages. Outside the block, a shared bias ramp steps through numbered bins and the current bin number is broadcast on a common bus. Each pixel slice watches its own avalanche-detect line. The first real breakdown it sees during the sweep latches the bin that was active at that moment. The slice then turns that bin into a signed correction code, which it holds for a local DAC.

A sweep is armed by a start pulse and closed by a sweep-end pulse from the ramp controller. Detect lines are asynchronous to the block. Each one passes through a synchronizer and a two-sample persistence filter, so a one-cycle glitch never counts. The bin bus is delayed by the same amount, so a captured bin is the one that was present while the detect line was high. A pixel that sees no breakdown before the sweep ends reports a failure and holds a zero correction. Calibration runs once per hard reset. After the done flag rises, every correction stays frozen until the next reset.

Top module: `bvcal_array`

## Requirements
- R1: While and after a hard reset (`rst` high at a clock edge), `done` is 0, every `fail` bit is 0 and every correction code is 0.
- R2: A sweep starts only when `cal_start` is seen while idle. A detection that occurs before the start pulse captures nothing.
- R3: The captured bin is the value that `bin_idx` held while the pixel's detect input was high for its first qualifying pair of consecutive cycles.
- R4: The correction is REF_BIN minus the captured bin, clamped to the two's-complement range of CODE_W bits. With the defaults (REF_BIN = 20, CODE_W = 5) the range is -16 to +15, and pixel p's code sits in `corr_code[p*5 +: 5]`.
- R5: Once a pixel has captured a bin, later breakdowns in the same sweep leave its correction unchanged.
- R6: A detect pulse that lasts a single cycle is rejected. A detection counts only when it is high for two consecutive cycles.
- R7: A pixel that has no qualifying detection when the sweep ends sets its `fail` bit (bit p for pixel p) and holds a correction of 0.
- R8: `done` rises in the cycle after `sweep_end` is sampled during a sweep, and then stays high. A `sweep_end` pulse seen while idle has no effect.
- R9: After `done`, further `cal_start`, `detect` and `sweep_end` activity does not change any correction or flag. Only a hard reset re-arms the calibration, after which a fresh sweep produces fresh results.
- R10: The pixels capture independently. One pixel's detections or failure do not affect another pixel's result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hard reset |
| cal_start | input | 1 | Pulse that arms one calibration sweep |
| sweep_end | input | 1 | Pulse from the ramp controller marking the final bin's end |
| bin_idx | input | BIN_W | Current bias bin number on the shared ramp |
| detect | input | NPIX | Asynchronous avalanche-detect line, one per pixel |
| corr_code | output | NPIX*CODE_W | Signed correction codes, pixel p at bits [p*CODE_W +: CODE_W] |
| fail | output | NPIX | Per-pixel flag: no breakdown seen during the sweep |
| done | output | 1 | Calibration finished; corrections frozen |

## Verification
Each pixel gets a different pattern of detects. A held detect inside one bin shows that the correct bin is captured, and bins are chosen inside the clamp range, exactly on both clamp limits and beyond them, so the subtraction and the saturation can each be told apart. A second held detect in a later bin separates first-event latching from last-event latching. A one-cycle pulse placed in an earlier bin shows whether the persistence filter works: if it fails, the earlier bin would be captured. Detects before the start pulse and after done, a sweep-end pulse while idle, and a sweep with silent pixels mixed with live ones check the arming, freeze, failure and independence rules.

// File: rtl/bvcal_pkg.sv
package bvcal_pkg;

    typedef enum logic [1:0] {
        CAL_IDLE  = 2'd0,
        CAL_SWEEP = 2'd1,
        CAL_DONE  = 2'd2
    } cal_state_e;

    typedef struct packed {
        logic captured;
        logic failed;
    } pix_flags_t;

    function automatic int clamp_int(input int v, input int lo, input int hi);
        if (v > hi)
            return hi;
        else if (v < lo)
            return lo;
        return v;
    endfunction

endpackage

// File: rtl/bvcal_det_filter.sv
module bvcal_det_filter #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic det_i,
    output logic hit_o
);
    logic [SYNC_STAGES:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst)
            chain_q <= '0;
        else
            chain_q <= {chain_q[SYNC_STAGES-1:0], det_i};
    end

    // Two consecutive synchronized samples must both be high
    assign hit_o = chain_q[SYNC_STAGES] & chain_q[SYNC_STAGES-1];

    assert_glitch_reject_R6: assert property (@(posedge clk) disable iff (rst)
        hit_o |-> ($past(det_i, SYNC_STAGES) && $past(det_i, SYNC_STAGES + 1)));

endmodule

// File: rtl/bvcal_seq.sv
module bvcal_seq
    import bvcal_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cal_start_i,
    input  logic sweep_end_i,
    output logic active_o,
    output logic finish_o,
    output logic done_o
);
    cal_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        case (state_q)
            CAL_IDLE:  if (cal_start_i) state_d = CAL_SWEEP;
            CAL_SWEEP: if (sweep_end_i) state_d = CAL_DONE;
            CAL_DONE:  state_d = CAL_DONE;
            default:   state_d = CAL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= CAL_IDLE;
        else
            state_q <= state_d;
    end

    assign active_o = (state_q == CAL_SWEEP);
    assign finish_o = active_o & sweep_end_i;
    assign done_o   = (state_q == CAL_DONE);

    assert_arm_on_start_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == CAL_IDLE && cal_start_i) |=> active_o);

    assert_done_on_end_R8: assert property (@(posedge clk) disable iff (rst)
        finish_o |=> done_o);

    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> done_o);

    assert_idle_end_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == CAL_IDLE && !cal_start_i) |=> !done_o);

endmodule

// File: rtl/bvcal_pixel.sv
module bvcal_pixel
    import bvcal_pkg::*;
#(
    parameter int BIN_W   = 6,
    parameter int CODE_W  = 5,
    parameter int REF_BIN = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active_i,
    input  logic              finish_i,
    input  logic              hit_i,
    input  logic [BIN_W-1:0]  bin_i,
    output logic [CODE_W-1:0] corr_o,
    output logic              fail_o
);
    localparam int CODE_MAX = (1 << (CODE_W - 1)) - 1;
    localparam int CODE_MIN = -(1 << (CODE_W - 1));

    pix_flags_t         flags_q;
    logic [CODE_W-1:0]  corr_q;
    logic [CODE_W-1:0]  corr_new;
    int                 diff;

    always_comb begin
        diff     = REF_BIN - int'(bin_i);
        corr_new = CODE_W'(clamp_int(diff, CODE_MIN, CODE_MAX));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            corr_q  <= '0;
        end else if (!flags_q.captured && !flags_q.failed) begin
            if (active_i && hit_i) begin
                flags_q.captured <= 1'b1;
                corr_q           <= corr_new;
            end else if (finish_i) begin
                flags_q.failed <= 1'b1;
                corr_q         <= '0;
            end
        end
    end

    assign corr_o = corr_q;
    assign fail_o = flags_q.failed;

    assert_capture_in_sweep_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(flags_q.captured) |-> $past(active_i));

    assert_first_event_held_R5: assert property (@(posedge clk) disable iff (rst)
        flags_q.captured |=> (flags_q.captured && $stable(corr_o)));

    assert_fail_zero_R7: assert property (@(posedge clk) disable iff (rst)
        fail_o |-> (corr_o == '0));

    assert_fail_needs_end_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(fail_o) |-> $past(finish_i));

endmodule

// File: rtl/bvcal_array.sv
module bvcal_array
    import bvcal_pkg::*;
#(
    parameter int NPIX        = 4,
    parameter int BIN_W       = 6,
    parameter int CODE_W      = 5,
    parameter int REF_BIN     = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cal_start,
    input  logic                   sweep_end,
    input  logic [BIN_W-1:0]       bin_idx,
    input  logic [NPIX-1:0]        detect,
    output logic [NPIX*CODE_W-1:0] corr_code,
    output logic [NPIX-1:0]        fail,
    output logic                   done
);
    localparam int BIN_DLY = SYNC_STAGES;

    logic active, finish;
    logic [BIN_W-1:0] bin_pipe_q [BIN_DLY];
    logic [BIN_W-1:0] bin_aligned;

    bvcal_seq seq_i (
        .clk         (clk),
        .rst         (rst),
        .cal_start_i (cal_start),
        .sweep_end_i (sweep_end),
        .active_o    (active),
        .finish_o    (finish),
        .done_o      (done)
    );

    // Delay the bin bus to line up with the detect filter latency
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < BIN_DLY; i++)
                bin_pipe_q[i] <= '0;
        end else begin
            bin_pipe_q[0] <= bin_idx;
            for (int i = 1; i < BIN_DLY; i++)
                bin_pipe_q[i] <= bin_pipe_q[i-1];
        end
    end

    assign bin_aligned = bin_pipe_q[BIN_DLY-1];

    for (genvar p = 0; p < NPIX; p++) begin : g_pix
        logic hit;

        bvcal_det_filter #(.SYNC_STAGES(SYNC_STAGES)) filt_i (
            .clk   (clk),
            .rst   (rst),
            .det_i (detect[p]),
            .hit_o (hit)
        );

        bvcal_pixel #(
            .BIN_W   (BIN_W),
            .CODE_W  (CODE_W),
            .REF_BIN (REF_BIN)
        ) pix_i (
            .clk      (clk),
            .rst      (rst),
            .active_i (active),
            .finish_i (finish),
            .hit_i    (hit),
            .bin_i    (bin_aligned),
            .corr_o   (corr_code[p*CODE_W +: CODE_W]),
            .fail_o   (fail[p])
        );
    end

    assert_frozen_after_done_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> ($stable(corr_code) && $stable(fail)));

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!done && fail == '0 && corr_code == '0));

endmodule

// File: tb/bvcal_array_tb_top.sv
`timescale 1ns/1ps
module bvcal_array_tb_top;
    localparam int NPIX   = 4;
    localparam int BIN_W  = 6;
    localparam int CODE_W = 5;
    localparam int REFB   = 20;
    localparam int NBINS  = 64;
    localparam int DWELL  = 8;

    logic clk = 1'b0;
    logic rst, cal_start, sweep_end;
    logic [BIN_W-1:0] bin_idx;
    logic [NPIX-1:0] detect;
    logic [NPIX*CODE_W-1:0] corr_code;
    logic [NPIX-1:0] fail;
    logic done;

    int n_tests = 0;
    int n_fail  = 0;
    int first_b [NPIX];
    int later_b [NPIX];
    int glitch_b[NPIX];

    always #2.5 clk = ~clk;

    bvcal_array dut_i (
        .clk(clk), .rst(rst), .cal_start(cal_start), .sweep_end(sweep_end),
        .bin_idx(bin_idx), .detect(detect), .corr_code(corr_code),
        .fail(fail), .done(done)
    );

    function automatic int exp_corr(input int b);
        int d;
        if (b < 0) return 0;
        d = REFB - b;
        if (d > 15) d = 15;
        if (d < -16) d = -16;
        return d;
    endfunction

    function automatic int corr_of(input int p);
        logic signed [CODE_W-1:0] c;
        c = corr_code[p*CODE_W +: CODE_W];
        return int'(c);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cal_start = 1'b0; sweep_end = 1'b0;
        detect = '0; bin_idx = '0;
        idle(2);
        rst = 1'b0;
        idle(1);
    endtask

    task automatic pulse_start();
        cal_start = 1'b1; idle(1); cal_start = 1'b0;
    endtask

    task automatic pulse_end();
        sweep_end = 1'b1; idle(1); sweep_end = 1'b0;
    endtask

    task automatic run_sweep();
        for (int b = 0; b < NBINS; b++) begin
            for (int c = 0; c < DWELL; c++) begin
                bin_idx = BIN_W'(b);
                for (int p = 0; p < NPIX; p++)
                    detect[p] = ((c >= 2 && c <= 5) && (b == first_b[p] || b == later_b[p]))
                                || (c == 2 && b == glitch_b[p]);
                idle(1);
            end
        end
        detect = '0;
        idle(4);
        check("R8 done low during sweep", int'(done), 0);
        pulse_end();
    endtask

    task automatic test_reset_state();
        do_reset();
        check("R1 done after reset", int'(done), 0);
        check("R1 fail after reset", int'(fail), 0);
        for (int p = 0; p < NPIX; p++)
            check("R1 corr after reset", corr_of(p), 0);
    endtask

    task automatic test_main_sweep();
        // R2: held detect before arming must not be captured
        bin_idx = '0;
        detect[0] = 1'b1; idle(4); detect[0] = 1'b0; idle(4);
        check("R2 no start yet", int'(done), 0);
        pulse_start();
        first_b  = '{18, 4, 22, 50};
        later_b  = '{30, -1, 40, 55};
        glitch_b = '{-1, -1, 10, -1};
        run_sweep();
        check("R8 done after sweep end", int'(done), 1);
        check("R7 no fail with breakdowns", int'(fail), 0);
        check("R3 R5 R2 pixel0 bin 18", corr_of(0), exp_corr(18));
        check("R4 pixel1 clamp high", corr_of(1), exp_corr(4));
        check("R6 R5 pixel2 bin 22", corr_of(2), exp_corr(22));
        check("R4 pixel3 clamp low", corr_of(3), exp_corr(50));
    endtask

    task automatic test_post_done();
        pulse_start();
        bin_idx = '0; detect = '1; idle(6); detect = '0;
        pulse_end(); idle(3);
        check("R9 done held", int'(done), 1);
        check("R9 fail unchanged", int'(fail), 0);
        check("R9 pixel0 frozen", corr_of(0), exp_corr(18));
        check("R9 pixel2 frozen", corr_of(2), exp_corr(22));
        check("R9 pixel3 frozen", corr_of(3), exp_corr(50));
    endtask

    task automatic test_fail_sweep();
        do_reset();
        check("R1 done cleared by reset", int'(done), 0);
        check("R1 corr cleared by reset", corr_of(0), 0);
        pulse_end(); idle(2);
        check("R8 idle sweep end ignored", int'(done), 0);
        pulse_start();
        first_b  = '{-1, 20, 10, -1};
        later_b  = '{-1, -1, -1, -1};
        glitch_b = '{-1, -1, -1, 7};
        run_sweep();
        check("R8 done after sweep", int'(done), 1);
        check("R7 R10 fail pattern", int'(fail), 9);
        check("R7 pixel0 zero", corr_of(0), 0);
        check("R4 pixel1 at reference", corr_of(1), 0);
        check("R10 pixel2 bin 10", corr_of(2), exp_corr(10));
        check("R7 R6 pixel3 glitch only", corr_of(3), 0);
    endtask

    task automatic test_rearm();
        do_reset();
        pulse_start();
        first_b  = '{5, 36, 0, 63};
        later_b  = '{-1, -1, -1, -1};
        glitch_b = '{-1, -1, -1, -1};
        run_sweep();
        check("R9 rerun done", int'(done), 1);
        check("R9 rerun fail", int'(fail), 0);
        check("R4 upper limit exact", corr_of(0), exp_corr(5));
        check("R4 lower limit exact", corr_of(1), exp_corr(36));
        check("R4 bin zero", corr_of(2), exp_corr(0));
        check("R3 last bin", corr_of(3), exp_corr(63));
    endtask

    initial begin
        rst = 1'b1; cal_start = 1'b0; sweep_end = 1'b0;
        detect = '0; bin_idx = '0;
        test_reset_state();
        test_main_sweep();
        test_post_done();
        test_fail_sweep();
        test_rearm();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule